// File: doc/BRIEF.md
# Transaction-Complete Address Queue

This block records which endpoint finished a transfer. Each time the protocol engine reports a successful transfer, it hands over the 16-bit address of that endpoint's descriptor-table entry. The block stores that address as a 16-bit word in a circular queue that lives in shared SRAM. The queue grows downward from a base address supplied on `tbl_base`. The block does not hold the storage itself. It issues a one-cycle write request on a simple memory write port and then moves its write pointer.

Both pointers are held as negative offsets from the base. They start at zero and count downward. A pointer that would step onto minus `DEPTH` comes back to zero, so entry k sits at `tbl_base + 2*ptr`.

Software empties the queue through a small register read port. Reading the read-pointer register both returns the entry position and pops it. Reading the other registers has no side effect. The completion flag `trn_flag` is high whenever the queue holds something, and this includes the full case, where the two pointers are equal again.

A controller tracks the queue occupancy with three named states:
- `Q_EMPTY`: nothing is queued.
- `Q_PART`: between 1 and `DEPTH-1` entries are queued.
- `Q_FULL`: `DEPTH` entries are queued.

Its transitions are:
- `T_FIRST`: from `Q_EMPTY` to `Q_PART` on an accepted push (or to `Q_FULL` when `DEPTH` is 1).
- `T_FILL`: from `Q_PART` to `Q_FULL` on a lone push at `DEPTH-1` entries.
- `T_LAST`: from `Q_PART` to `Q_EMPTY` on a lone pop at 1 entry.
- `T_UNFULL`: from `Q_FULL` to `Q_PART` on a pop (or to `Q_EMPTY` when `DEPTH` is 1).
- `T_HOLD`: every other case, where the state stays the same.

Every decision uses the state held at the start of the cycle.

Top module: `tcq_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both pointers, the overflow bit and `rd_data` to zero. After reset, `trn_flag` and `mem_we` are low.
- R2: A `xfer_done` pulse while the queue is not full causes the following write one cycle later: `mem_we` high for exactly that cycle, `mem_addr` = `tbl_base` + 2 × (write pointer before the push, sign-extended), and `mem_wdata` = `xfer_desc`. The write pointer then moves down by one. With no accepted push, `mem_we` stays low.
- R3: Each pointer steps 0 → −1 → … → −(DEPTH−1) → 0. When read, a pointer is returned in `rd_data` as an 8-bit two's-complement value; for example, −3 reads as 8'hFD.
- R4: A read with `rd_sel` = 1 on a non-empty queue places the read pointer's value from before the read in `rd_data` one cycle later, and decrements the read pointer. `tbl_base` + 2 × that value is the address of the oldest queued entry.
- R5: A read with `rd_sel` = 1 on an empty queue returns the read pointer but leaves it unchanged.
- R6: Reads with `rd_sel` = 0 (write pointer), 2 (count) or 3 (status) change no pointer. `rd_data` holds its last value whenever `rd_en` is low.
- R7: A read with `rd_sel` = 2 returns the number of queued entries, 0 to DEPTH, zero-extended.
- R8: `trn_flag` is high exactly when the pointers differ or the queue is full. A read with `rd_sel` = 3 returns the flag in bit 0.
- R9: A `xfer_done` while the queue holds DEPTH entries is dropped: no memory write and no pointer move. It sets a sticky overflow bit, read as bit 1 of `rd_sel` = 3, which only reset clears.
- R10: A push and a pop in the same cycle on a partly filled queue are both applied, and the count is unchanged.
- R11: A push and a pop in the same cycle on a full queue apply the pop, drop the push and set the overflow bit. The count ends at DEPTH−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_done | input | 1 | One-cycle strobe: an endpoint transfer completed |
| xfer_desc | input | 16 | Descriptor-table address to record |
| tbl_base | input | 16 | Base address of the queue area in SRAM |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select: 0 write pointer, 1 read pointer (pops), 2 count, 3 status |
| rd_data | output | 8 | Registered read result, valid the cycle after `rd_en` |
| mem_we | output | 1 | One-cycle memory write enable |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| trn_flag | output | 1 | Completion flag: queue non-empty or full |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- **Pointer wrap at minus DEPTH.** A design that wraps one step early or late writes records to the wrong addresses.
- **Full queue with equal pointers.** A flag built only from pointer inequality drops when the queue fills.
- **Push that arrives while full.** If accepted, it overwrites the oldest record and loses the overflow indication.
- **Pop on an empty queue.** If it still decremented, the read pointer would run ahead of the write pointer.

Simultaneous push and pop are exercised in both the partly filled and the full state, where a design that ignores one of them shows a wrong count. Every popped position is compared against the address at which the model saw the matching record written.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

    typedef enum logic [1:0] {
        SEL_WPTR   = 2'd0,
        SEL_RPTR   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tcq_ptr.sv
// Downward-counting queue pointer held as a negative offset from the base.
module tcq_ptr #(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam int               WRAP_I  = (1 << PTR_W) - DEPTH;
    localparam logic [PTR_W-1:0] WRAP_AT = WRAP_I[PTR_W-1:0];

    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_nxt;

    always_comb begin
        ptr_dec = ptr - PTR_W'(1);
        if (ptr_dec == WRAP_AT) begin
            ptr_nxt = '0;
        end else begin
            ptr_nxt = ptr_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr_nxt;
        end
    end
endmodule

// File: rtl/tcq_ctrl.sv
// Occupancy state machine, count and overflow tracking.
module tcq_ctrl
    import tcq_pkg::*;
#(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             drop,
    output q_state_e         state,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ALMOST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PTR_W:0]   DEPTH_X = (PTR_W + 1)'(DEPTH);

    q_state_e         state_nxt;
    logic [PTR_W-1:0] idx_w;
    logic [PTR_W-1:0] idx_r;
    logic [PTR_W:0]   diff;

    // Occupancy from pointer distance; full needs the state to disambiguate.
    always_comb begin
        idx_w = '0 - wr_ptr;
        idx_r = '0 - rd_ptr;
        diff  = {1'b0, idx_w} - {1'b0, idx_r};
        if (diff[PTR_W]) begin
            diff = diff + DEPTH_X;
        end
        if (state == Q_FULL) begin
            count = CNT_FULL;
        end else begin
            count = CNT_W'(diff);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= Q_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (push_ok) begin                            // T_FIRST
                    state_nxt = (DEPTH == 1) ? Q_FULL : Q_PART;
                end
            end
            Q_PART: begin
                if (push_ok && !pop_ok && count == CNT_ALMOST) begin
                    state_nxt = Q_FULL;                       // T_FILL
                end else if (pop_ok && !push_ok && count == CNT_ONE) begin
                    state_nxt = Q_EMPTY;                      // T_LAST
                end
            end
            Q_FULL: begin
                if (pop_ok) begin                             // T_UNFULL
                    state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PART;
                end
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // Outputs decided from the state held at the start of the cycle
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        drop    = 1'b0;
        unique case (state)
            Q_EMPTY: begin
                push_ok = push_req;
            end
            Q_PART: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            Q_FULL: begin
                pop_ok = pop_req;
                drop   = push_req;
            end
            default: begin
                push_ok = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/tcq_memwr.sv
// Registered single-cycle write request into the shared SRAM.
module tcq_memwr #(
    parameter int PTR_W = 5,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_ok,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [AW-1:0]    base,
    input  logic [DW-1:0]    desc,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata
);
    logic [AW-1:0] offs;
    logic [AW-1:0] slot_addr;

    always_comb begin
        offs      = {{(AW - PTR_W){wr_ptr[PTR_W-1]}}, wr_ptr};
        slot_addr = base + (offs << 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= push_ok;
            if (push_ok) begin
                mem_addr  <= slot_addr;
                mem_wdata <= desc;
            end
        end
    end
endmodule

// File: rtl/tcq_regrd.sv
// Register read mux with registered result.
module tcq_regrd
    import tcq_pkg::*;
#(
    parameter int PTR_W = 5,
    parameter int CNT_W = 5,
    parameter int RD_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [CNT_W-1:0] count,
    input  logic             ovf,
    input  logic             flag,
    output logic [RD_W-1:0]  rd_data
);
    logic [RD_W-1:0] rd_mux;

    always_comb begin
        unique case (sel)
            SEL_WPTR:   rd_mux = {{(RD_W - PTR_W){wr_ptr[PTR_W-1]}}, wr_ptr};
            SEL_RPTR:   rd_mux = {{(RD_W - PTR_W){rd_ptr[PTR_W-1]}}, rd_ptr};
            SEL_COUNT:  rd_mux = {{(RD_W - CNT_W){1'b0}}, count};
            SEL_STATUS: rd_mux = {{(RD_W - 2){1'b0}}, ovf, flag};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/tcq_fifo.sv
// Transaction-complete address queue, top level.
module tcq_fifo
    import tcq_pkg::*;
#(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int RD_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer_done,
    input  logic [DW-1:0]   xfer_desc,
    input  logic [AW-1:0]   tbl_base,
    input  logic            rd_en,
    input  logic [1:0]      rd_sel,
    output logic [RD_W-1:0] rd_data,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            trn_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_sel_e         sel_e;
    logic             pop_req;
    logic             push_ok;
    logic             pop_ok;
    logic             drop;
    logic             ovf_q;
    q_state_e         q_state;
    logic [CNT_W-1:0] q_count;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign sel_e    = reg_sel_e'(rd_sel);
    assign pop_req  = rd_en && (sel_e == SEL_RPTR);
    assign trn_flag = (q_state != Q_EMPTY);

    tcq_ptr #(.PTR_W(PTR_W), .DEPTH(DEPTH)) wp_i (
        .clk  (clk),
        .rst  (rst),
        .step (push_ok),
        .ptr  (wr_ptr)
    );

    tcq_ptr #(.PTR_W(PTR_W), .DEPTH(DEPTH)) rp_i (
        .clk  (clk),
        .rst  (rst),
        .step (pop_ok),
        .ptr  (rd_ptr)
    );

    tcq_ctrl #(.PTR_W(PTR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .push_req (xfer_done),
        .pop_req  (pop_req),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .state    (q_state),
        .count    (q_count),
        .ovf      (ovf_q)
    );

    tcq_memwr #(.PTR_W(PTR_W), .AW(AW), .DW(DW)) memwr_i (
        .clk       (clk),
        .rst       (rst),
        .push_ok   (push_ok),
        .wr_ptr    (wr_ptr),
        .base      (tbl_base),
        .desc      (xfer_desc),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    tcq_regrd #(.PTR_W(PTR_W), .CNT_W(CNT_W), .RD_W(RD_W)) regrd_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .sel     (sel_e),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (q_count),
        .ovf     (ovf_q),
        .flag    (trn_flag),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/tcq_fifo_chk.sv
module tcq_fifo_chk
    import tcq_pkg::*;
#(
    parameter int PTR_W = 5,
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             xfer_done,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic             mem_we,
    input logic             trn_flag,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input q_state_e         q_state,
    input logic [CNT_W-1:0] q_count,
    input logic             ovf_q
);
    AST_PUSH_WRITES: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && q_state != Q_FULL) |=> mem_we); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !xfer_done |=> !mem_we); // R2
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && q_state == Q_FULL) |=> (!mem_we && ovf_q)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R9
    AST_READ_INERT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel != 2'd1 && !xfer_done) |=> ($stable(wr_ptr) && $stable(rd_ptr))); // R6
    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (rst)
        (q_state == Q_EMPTY && !xfer_done) |=> $stable(rd_ptr)); // R5
    AST_BOTH_MOVE: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && rd_en && rd_sel == 2'd1 && q_state == Q_PART) |=> $stable(q_count)); // R10
    AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
        trn_flag == ((wr_ptr != rd_ptr) || q_state == Q_FULL)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH)); // R7
endmodule

bind tcq_fifo tcq_fifo_chk #(.PTR_W(PTR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .xfer_done (xfer_done),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .mem_we    (mem_we),
    .trn_flag  (trn_flag),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .q_state   (q_state),
    .q_count   (q_count),
    .ovf_q     (ovf_q)
);

// File: tb/tcq_fifo_tb_top.sv
`timescale 1ns/1ps
module tcq_fifo_tb_top;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_done = 1'b0;
    logic [15:0] xfer_desc = '0;
    logic [15:0] tbl_base = 16'h0400;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        trn_flag;

    always #2 clk = ~clk;

    tcq_fifo dut_i (
        .clk       (clk),
        .rst       (rst),
        .xfer_done (xfer_done),
        .xfer_desc (xfer_desc),
        .tbl_base  (tbl_base),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .trn_flag  (trn_flag)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    int          wp_m = 0;
    int          rp_m = 0;
    int          cnt_m = 0;
    bit          ovf_m = 1'b0;
    logic [7:0]  rd_hold = '0;
    logic [15:0] adr_q[$];

    function automatic int dec_m(int p);
        if (p - 1 == -D) return 0;
        return p - 1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, let the edge pass, compare against the model.
    task automatic step(bit done, logic [15:0] desc, bit ren, logic [1:0] sel, string tg = "");
        bit          push_ok;
        bit          pop_ok;
        bit          drop;
        logic [15:0] exp_addr;
        logic [15:0] popped;
        string       stag;
        xfer_done = done;
        xfer_desc = desc;
        rd_en     = ren;
        rd_sel    = sel;
        push_ok   = done && (cnt_m < D);
        drop      = done && (cnt_m == D);
        pop_ok    = ren && (sel == 2'd1) && (cnt_m > 0);
        exp_addr  = tbl_base + 16'(2 * wp_m);
        popped    = '0;
        stag      = "R6";
        if (ren) begin
            case (sel)
                2'd0: rd_hold = 8'(wp_m);
                2'd1: begin
                    rd_hold = 8'(rp_m);
                    stag = (cnt_m > 0) ? "R4" : "R5";
                end
                2'd2: begin
                    rd_hold = 8'(cnt_m);
                    stag = "R7";
                end
                default: begin
                    rd_hold = {6'b0, ovf_m, (cnt_m != 0)};
                    stag = "R9";
                end
            endcase
        end
        if (tg != "") stag = tg;
        if (push_ok) begin
            adr_q.push_back(exp_addr);
            wp_m = dec_m(wp_m);
            cnt_m++;
        end
        if (pop_ok) begin
            popped = adr_q.pop_front();
            rp_m = dec_m(rp_m);
            cnt_m--;
        end
        if (drop) ovf_m = 1'b1;
        @(posedge clk);
        #1;
        check(mem_we == push_ok, drop ? "R9" : "R2", "mem_we", int'(mem_we), int'(push_ok));
        if (push_ok) begin
            check(mem_addr == exp_addr, "R2", "mem_addr", int'(mem_addr), int'(exp_addr));
            check(mem_wdata == desc, "R2", "mem_wdata", int'(mem_wdata), int'(desc));
        end
        check(trn_flag == (cnt_m != 0), "R8", "trn_flag", int'(trn_flag), int'(cnt_m != 0));
        check(rd_data == rd_hold, stag, "rd_data", int'(rd_data), int'(rd_hold));
        if (pop_ok) begin
            check(tbl_base + 16'(2 * int'($signed(rd_data))) == popped, "R4", "popped slot",
                  int'(tbl_base + 16'(2 * int'($signed(rd_data)))), int'(popped));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(trn_flag == 1'b0, "R1", "flag after reset", int'(trn_flag), 0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);
        check(rd_data == 8'h00, "R1", "rd_data after reset", int'(rd_data), 0);
        rst = 1'b0;
        step(0, 16'h0, 1, 2'd0, "R1");
        step(0, 16'h0, 1, 2'd1, "R1");
        step(0, 16'h0, 1, 2'd2, "R1");
        step(0, 16'h0, 1, 2'd3, "R1");
        // three records, then pointer, count and status
        for (int i = 0; i < 3; i++) step(1, 16'hA000 + 16'(i), 0, 2'd0);
        step(0, 16'h0, 1, 2'd0, "R3");
        step(0, 16'h0, 1, 2'd2, "R7");
        step(0, 16'h0, 1, 2'd3, "R8");
        // pop once, inert reads, second pop shows a single step
        step(0, 16'h0, 1, 2'd1, "R4");
        step(0, 16'h0, 1, 2'd0, "R6");
        step(0, 16'h0, 1, 2'd2, "R6");
        step(0, 16'h0, 1, 2'd1, "R4");
        // simultaneous push and pop on a partly filled queue
        step(1, 16'hB001, 1, 2'd1, "R10");
        step(0, 16'h0, 1, 2'd2, "R10");
        // drain, then pops on empty
        while (cnt_m > 0) step(0, 16'h0, 1, 2'd1);
        step(0, 16'h0, 1, 2'd1, "R5");
        step(0, 16'h0, 1, 2'd1, "R5");
        step(0, 16'h0, 1, 2'd2, "R5");
        // fill to full across the wrap point
        for (int i = 0; i < D; i++) step(1, 16'hC000 + 16'(i), 0, 2'd0);
        step(0, 16'h0, 1, 2'd2, "R7");
        step(0, 16'h0, 1, 2'd0, "R3");
        step(0, 16'h0, 1, 2'd3, "R8");
        step(1, 16'hDEAD, 0, 2'd0);
        step(0, 16'h0, 1, 2'd3, "R9");
        step(0, 16'h0, 1, 2'd0, "R9");
        // push and pop together while full
        step(1, 16'hBEEF, 1, 2'd1, "R11");
        step(0, 16'h0, 1, 2'd2, "R11");
        step(0, 16'h0, 1, 2'd3, "R11");
        while (cnt_m > 0) step(0, 16'h0, 1, 2'd1);
        step(0, 16'h0, 1, 2'd1, "R3");
        // mixed traffic with a different base
        tbl_base = 16'h1F00;
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 100) < 45, 16'($urandom), ($urandom % 2) == 1, 2'($urandom));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule